// File: doc/BRIEF.md
# PLL power-up and lock sequencer

This block is a finite-state machine that controls a PLL and its output path. When asked to power up, it turns on the bias and sets the system mux code on the master PHY. It repeats those two steps on a secondary PHY when one was present at the request. It then starts the PLL and polls a lock-status input on a coarse interval, with a hard timeout. When lock is seen, it opens the global clock gates and then the readback buffers. When asked to power down, it closes the clock gate before the PLL stops and then tears down each PHY's output path and bias. Every wait is counted in cycles of the reference clock. The cycle counts come from parameters that give the clock frequency and the wait times in nanoseconds.

The register bus and the analog PLL are outside this block. Requests are single-cycle pulses. The control outputs are plain levels that drive the PHY controls directly.

Top module: `pll_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, all control outputs are low, both mux codes are 0, and `pll_on_o` and `err_o` are low.
- R2: On each PHY, power-up sets the bias first and the mux code one cycle later. At least SETTLE_CYC cycles pass between the mux write and the next step, where SETTLE_CYC = ceil(REF_HZ*SETTLE_NS/1e9).
- R3: A mux code output only ever holds 0x00 (cleared) or 0xC0 (active).
- R4: The PLL run control rises only after the master bias steps are done and settled, and after the slave's bias steps too when a slave is in use.
- R5: Lock is sampled every POLL_CYC = ceil(REF_HZ*POLL_NS/1e9) cycles, the first sample POLL_CYC cycles after run rises. `pll_on_o` rises at the first sample that sees lock high. If MAX_POLLS = ceil(TIMEOUT_NS/POLL_NS) samples all miss lock, `err_o` rises exactly MAX_POLLS*POLL_CYC cycles after run.
- R6: `pll_on_o` is high only from a successful lock until power-down begins, and its fall is the first change that power-down makes.
- R7: After `pll_on_o` rises, the outputs change one per cycle in this order: master gate, slave gate, master buffer, slave buffer. After a lock timeout, the gates, the buffers and `pll_on_o` stay low.
- R8: Power-down changes the outputs one per cycle in this order: master gate off, run off, master buffer off, master mux 0, master bias off, then a settle of at least SETTLE_CYC. With a slave, the order continues with slave gate off, slave buffer off, slave mux 0, slave bias off and another settle.
- R9: Slave presence is sampled only when a power-up request is accepted. Slave outputs move only in sequences that began with it set.
- R10: A power-up request is accepted only when the block is idle, after the final settle. A power-down request is accepted only in the locked or failed state. Requests at other times, and lock changes outside a poll sample, cause no output change.
- R11: `err_o` stays high until the next accepted power-up request. It clears one cycle before the master bias rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| up_req_i | input | 1 | Power-up request pulse |
| down_req_i | input | 1 | Power-down request pulse |
| slave_en_i | input | 1 | Secondary PHY present, sampled at power-up |
| lock_i | input | 1 | PLL lock status |
| bias_o | output | 1 | Master bias enable |
| mux_o | output | 8 | Master system mux code |
| pll_run_o | output | 1 | PLL run control |
| gate_o | output | 1 | Master global clock gate open |
| rbuf_o | output | 1 | Master readback buffer enable |
| slv_bias_o | output | 1 | Slave bias enable |
| slv_mux_o | output | 8 | Slave system mux code |
| slv_gate_o | output | 1 | Slave global clock gate open |
| slv_rbuf_o | output | 1 | Slave readback buffer enable |
| pll_on_o | output | 1 | PLL locked and output path live |
| err_o | output | 1 | Lock timeout, latched |

## Verification
The assertions assume that requests are single-cycle pulses and that lock only matters at poll samples. They assume nothing about when requests arrive, because the sequencer ignores requests in the wrong state by design. The stimulus sends every request as a one-cycle pulse on the falling edge and changes lock only on falling edges. It also sends deliberate requests out of state and mid-sequence slave-select changes, so the ignore rules get exercised while the ordering properties stay meaningful.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef longint unsigned u64_t;

  localparam logic [7:0] MUX_ACTIVE = 8'hC0;

  typedef struct packed {
    logic bias_set;
    logic bias_clr;
    logic mux_set;
    logic mux_clr;
    logic gate_set;
    logic gate_clr;
    logic rbuf_set;
    logic rbuf_clr;
  } side_cmd_t;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_BIAS,
    ST_MUX,
    ST_SETTLE,
    ST_RUN,
    ST_POLL,
    ST_GATE,
    ST_RBUF,
    ST_ON,
    ST_FAIL,
    ST_DOFF,
    ST_DGATE,
    ST_DRUN,
    ST_DRBUF,
    ST_DMUX,
    ST_DBIAS,
    ST_DSETTLE
  } seq_state_e;
endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pll_seq_side.sv
module pll_seq_side
  import pll_seq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  side_cmd_t cmd_i,
  output logic      bias_o,
  output logic [7:0] mux_o,
  output logic      gate_o,
  output logic      rbuf_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bias_o <= 1'b0;
      mux_o  <= '0;
      gate_o <= 1'b0;
      rbuf_o <= 1'b0;
    end else begin
      if (cmd_i.bias_set)      bias_o <= 1'b1;
      else if (cmd_i.bias_clr) bias_o <= 1'b0;
      if (cmd_i.mux_set)       mux_o  <= MUX_ACTIVE;
      else if (cmd_i.mux_clr)  mux_o  <= '0;
      if (cmd_i.gate_set)      gate_o <= 1'b1;
      else if (cmd_i.gate_clr) gate_o <= 1'b0;
      if (cmd_i.rbuf_set)      rbuf_o <= 1'b1;
      else if (cmd_i.rbuf_clr) rbuf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
  import pll_seq_pkg::*;
#(
  parameter int unsigned TW          = 8,
  parameter int unsigned PW          = 4,
  parameter int unsigned SETTLE_LOAD = 1,
  parameter int unsigned POLL_LOAD   = 1,
  parameter int unsigned POLL_LAST   = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 up_req_i,
  input  logic                 down_req_i,
  input  logic                 slave_en_i,
  input  logic                 lock_i,
  input  logic                 tmr_done_i,
  output logic                 tmr_load_o,
  output logic [TW-1:0]        tmr_val_o,
  output side_cmd_t [1:0]      cmd_o,
  output logic                 run_o,
  output logic                 pll_on_o,
  output logic                 err_o
);
  seq_state_e    state_q, state_d;
  logic          side_q, side_d;
  logic          slv_q, slv_d;
  logic [PW-1:0] polls_q, polls_d;
  logic          run_q, run_d, on_q, on_d, err_q, err_d;

  // true when the current step must be repeated on the slave
  logic to_slave;
  assign to_slave = !side_q && slv_q;

  always_comb begin
    state_d    = state_q;
    side_d     = side_q;
    slv_d      = slv_q;
    polls_d    = polls_q;
    run_d      = run_q;
    on_d       = on_q;
    err_d      = err_q;
    cmd_o      = '0;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_IDLE: if (up_req_i) begin
        err_d   = 1'b0;
        slv_d   = slave_en_i;
        side_d  = 1'b0;
        state_d = ST_BIAS;
      end
      ST_BIAS: begin
        cmd_o[side_q].bias_set = 1'b1;
        state_d = ST_MUX;
      end
      ST_MUX: begin
        cmd_o[side_q].mux_set = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(SETTLE_LOAD);
        state_d    = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_done_i) begin
        if (to_slave) begin
          side_d  = 1'b1;
          state_d = ST_BIAS;
        end else begin
          side_d  = 1'b0;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        run_d      = 1'b1;
        polls_d    = '0;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(POLL_LOAD);
        state_d    = ST_POLL;
      end
      ST_POLL: if (tmr_done_i) begin
        if (lock_i) begin
          on_d    = 1'b1;
          state_d = ST_GATE;
        end else if (polls_q == PW'(POLL_LAST)) begin
          err_d   = 1'b1;
          state_d = ST_FAIL;
        end else begin
          polls_d    = polls_q + 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = TW'(POLL_LOAD);
        end
      end
      ST_GATE: begin
        cmd_o[side_q].gate_set = 1'b1;
        side_d  = to_slave;
        state_d = to_slave ? ST_GATE : ST_RBUF;
      end
      ST_RBUF: begin
        cmd_o[side_q].rbuf_set = 1'b1;
        side_d  = to_slave;
        state_d = to_slave ? ST_RBUF : ST_ON;
      end
      ST_ON:   if (down_req_i) state_d = ST_DOFF;
      ST_FAIL: if (down_req_i) begin
        side_d  = 1'b0;
        state_d = ST_DGATE;
      end
      ST_DOFF: begin
        on_d    = 1'b0;
        side_d  = 1'b0;
        state_d = ST_DGATE;
      end
      ST_DGATE: begin
        cmd_o[side_q].gate_clr = 1'b1;
        state_d = side_q ? ST_DRBUF : ST_DRUN;
      end
      ST_DRUN: begin
        run_d   = 1'b0;
        state_d = ST_DRBUF;
      end
      ST_DRBUF: begin
        cmd_o[side_q].rbuf_clr = 1'b1;
        state_d = ST_DMUX;
      end
      ST_DMUX: begin
        cmd_o[side_q].mux_clr = 1'b1;
        state_d = ST_DBIAS;
      end
      ST_DBIAS: begin
        cmd_o[side_q].bias_clr = 1'b1;
        tmr_load_o = 1'b1;
        tmr_val_o  = TW'(SETTLE_LOAD);
        state_d    = ST_DSETTLE;
      end
      ST_DSETTLE: if (tmr_done_i) begin
        side_d  = to_slave;
        state_d = to_slave ? ST_DGATE : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      side_q  <= 1'b0;
      slv_q   <= 1'b0;
      polls_q <= '0;
      run_q   <= 1'b0;
      on_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      side_q  <= side_d;
      slv_q   <= slv_d;
      polls_q <= polls_d;
      run_q   <= run_d;
      on_q    <= on_d;
      err_q   <= err_d;
    end
  end

  assign run_o    = run_q;
  assign pll_on_o = on_q;
  assign err_o    = err_q;
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int unsigned REF_HZ     = 200_000_000,
  parameter int unsigned SETTLE_NS  = 250,
  parameter int unsigned POLL_NS    = 100_000,
  parameter int unsigned TIMEOUT_NS = 5_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       up_req_i,
  input  logic       down_req_i,
  input  logic       slave_en_i,
  input  logic       lock_i,
  output logic       bias_o,
  output logic [7:0] mux_o,
  output logic       pll_run_o,
  output logic       gate_o,
  output logic       rbuf_o,
  output logic       slv_bias_o,
  output logic [7:0] slv_mux_o,
  output logic       slv_gate_o,
  output logic       slv_rbuf_o,
  output logic       pll_on_o,
  output logic       err_o
);
  localparam u64_t NS_PER_S   = 64'd1_000_000_000;
  localparam u64_t SETTLE_RAW = (u64_t'(REF_HZ) * u64_t'(SETTLE_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam u64_t POLL_RAW   = (u64_t'(REF_HZ) * u64_t'(POLL_NS) + NS_PER_S - 1) / NS_PER_S;
  localparam u64_t SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam u64_t POLL_CYC   = (POLL_RAW < 1) ? 1 : POLL_RAW;
  localparam u64_t POLLS_RAW  = (u64_t'(TIMEOUT_NS) + u64_t'(POLL_NS) - 1) / u64_t'(POLL_NS);
  localparam u64_t MAX_POLLS  = (POLLS_RAW < 1) ? 1 : POLLS_RAW;
  localparam u64_t TMR_MAX    = (SETTLE_CYC > POLL_CYC) ? SETTLE_CYC : POLL_CYC;
  localparam int unsigned TW  = ($clog2(TMR_MAX) < 1) ? 1 : $clog2(TMR_MAX);
  localparam int unsigned PW  = ($clog2(MAX_POLLS) < 1) ? 1 : $clog2(MAX_POLLS);
  localparam int unsigned NSIDE = 2;

  logic            tmr_load, tmr_done;
  logic [TW-1:0]   tmr_val;
  side_cmd_t [NSIDE-1:0] cmd;
  logic [NSIDE-1:0]      bias_w, gate_w, rbuf_w;
  logic [NSIDE-1:0][7:0] mux_w;

  pll_seq_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  pll_seq_fsm #(
    .TW          (TW),
    .PW          (PW),
    .SETTLE_LOAD (int'(SETTLE_CYC - 1)),
    .POLL_LOAD   (int'(POLL_CYC - 1)),
    .POLL_LAST   (int'(MAX_POLLS - 1))
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .up_req_i   (up_req_i),
    .down_req_i (down_req_i),
    .slave_en_i (slave_en_i),
    .lock_i     (lock_i),
    .tmr_done_i (tmr_done),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .cmd_o      (cmd),
    .run_o      (pll_run_o),
    .pll_on_o   (pll_on_o),
    .err_o      (err_o)
  );

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    pll_seq_side u_side (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd[g]),
      .bias_o (bias_w[g]),
      .mux_o  (mux_w[g]),
      .gate_o (gate_w[g]),
      .rbuf_o (rbuf_w[g])
    );
  end

  assign bias_o     = bias_w[0];
  assign mux_o      = mux_w[0];
  assign gate_o     = gate_w[0];
  assign rbuf_o     = rbuf_w[0];
  assign slv_bias_o = bias_w[1];
  assign slv_mux_o  = mux_w[1];
  assign slv_gate_o = gate_w[1];
  assign slv_rbuf_o = rbuf_w[1];
endmodule

// File: rtl/pll_seq_ctrl_chk.sv
module pll_seq_ctrl_chk
  import pll_seq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       up_req_i,
  input logic       down_req_i,
  input logic       slave_en_i,
  input logic       lock_i,
  input logic       bias_o,
  input logic [7:0] mux_o,
  input logic       pll_run_o,
  input logic       gate_o,
  input logic       rbuf_o,
  input logic       slv_bias_o,
  input logic [7:0] slv_mux_o,
  input logic       slv_gate_o,
  input logic       slv_rbuf_o,
  input logic       pll_on_o,
  input logic       err_o
);
  // R3
  mux_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_o == 8'h00 || mux_o == MUX_ACTIVE) && (slv_mux_o == 8'h00 || slv_mux_o == MUX_ACTIVE));

  // R2
  mux_needs_bias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mux_o != 8'h00 |-> bias_o) and (slv_mux_o != 8'h00 |-> slv_bias_o));

  // R4
  run_after_bias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_run_o) |-> bias_o && mux_o == MUX_ACTIVE);

  // R7
  gate_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> pll_run_o && bias_o);

  // R7
  gate_after_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(pll_on_o));

  // R8
  gate_before_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_run_o) |-> !gate_o);

  // R7
  fail_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !gate_o && !rbuf_o && !slv_gate_o && !slv_rbuf_o);

  // R6
  on_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_on_o |-> pll_run_o && !err_o);

  // R6
  on_falls_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pll_on_o) |-> gate_o && pll_run_o);
endmodule

bind pll_seq_ctrl pll_seq_ctrl_chk u_chk (.*);

// File: tb/pll_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pll_seq_ctrl_bench;
  localparam int unsigned REF_HZ     = 200_000_000;
  localparam int unsigned SETTLE_NS  = 250;
  localparam int unsigned POLL_NS    = 200;
  localparam int unsigned TIMEOUT_NS = 1000;
  // expected cycle counts from the timing requirements
  localparam int S = 50;   // 250 ns at 5 ns
  localparam int P = 40;   // 200 ns at 5 ns
  localparam int M = 5;    // 1000 / 200

  localparam int I_BIAS = 0, I_MUX = 1, I_RUN = 2, I_GATE = 3, I_RBUF = 4;
  localparam int I_SBIAS = 5, I_SMUX = 6, I_SGATE = 7, I_SRBUF = 8, I_ON = 9, I_ERR = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic up_req_i = 1'b0, down_req_i = 1'b0, slave_en_i = 1'b0, lock_i = 1'b0;
  logic bias_o, pll_run_o, gate_o, rbuf_o, slv_bias_o, slv_gate_o, slv_rbuf_o, pll_on_o, err_o;
  logic [7:0] mux_o, slv_mux_o;

  always #2.5 clk_i = ~clk_i;

  pll_seq_ctrl #(
    .REF_HZ(REF_HZ), .SETTLE_NS(SETTLE_NS), .POLL_NS(POLL_NS), .TIMEOUT_NS(TIMEOUT_NS)
  ) u_pll_seq_ctrl (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, ev_cnt = 0;
  bit done = 1'b0;
  int ev_time [11];
  int    exp_idx [$];
  bit    exp_val [$];
  string exp_tag [$];
  logic [10:0] prev_obs = '0;

  function automatic logic [10:0] obs();
    return {err_o, pll_on_o, slv_rbuf_o, slv_gate_o, (slv_mux_o != 0), slv_bias_o,
            rbuf_o, gate_o, pll_run_o, (mux_o != 0), bias_o};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push(input int idx, input bit val, input string tag);
    exp_idx.push_back(idx);
    exp_val.push_back(val);
    exp_tag.push_back(tag);
  endtask

  task automatic pulse_up();
    up_req_i = 1'b1; @(negedge clk_i); up_req_i = 1'b0;
  endtask

  task automatic pulse_down();
    down_req_i = 1'b1; @(negedge clk_i); down_req_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (exp_idx.size() != 0 && w < 3000) begin
      @(negedge clk_i);
      w++;
    end
    check(exp_idx.size() == 0, tag, "events still pending", exp_idx.size(), 0);
    repeat (S + 10) @(negedge clk_i);
  endtask

  // monitor: one output change per cycle, popped against the expected queue
  always @(negedge clk_i) begin
    logic [10:0] cur, diff;
    int idx;
    cyc++;
    if (rst_ni) begin
      cur  = obs();
      diff = cur ^ prev_obs;
      if (diff != '0) begin
        ev_cnt++;
        idx = 0;
        for (int i = 0; i < 11; i++) if (diff[i]) idx = i;
        ev_time[idx] = cyc;
        check($countones(diff) == 1, "R8", "outputs changed in one cycle", $countones(diff), 1);
        if (exp_idx.size() == 0) begin
          check(1'b0, "R10", "unexpected change on output index", idx, -1);
        end else begin
          int e_i; bit e_v; string e_t;
          e_i = exp_idx.pop_front(); e_v = exp_val.pop_front(); e_t = exp_tag.pop_front();
          check(e_i == idx && e_v == cur[idx], e_t, "event index*2+value", idx*2 + cur[idx], e_i*2 + e_v);
        end
        if (idx == I_MUX && cur[idx])  check(mux_o == 8'hC0, "R3", "master mux code", mux_o, 8'hC0);
        if (idx == I_SMUX && cur[idx]) check(slv_mux_o == 8'hC0, "R3", "slave mux code", slv_mux_o, 8'hC0);
        if (idx == I_MUX && !cur[idx]) check(mux_o == 8'h00, "R3", "master mux cleared", mux_o, 0);
      end
      prev_obs = cur;
    end
  end

  always @(negedge clk_i) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      check(1'b0, "R1", "watchdog expired at cycle", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(obs() == '0 && mux_o == 0 && slv_mux_o == 0, "R1", "outputs in reset", obs(), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(obs() == '0, "R1", "outputs after reset", obs(), 0);

    // power-up, master only, lock already present
    lock_i = 1'b1;
    push(I_BIAS, 1, "R2"); push(I_MUX, 1, "R2"); push(I_RUN, 1, "R4");
    push(I_ON, 1, "R6"); push(I_GATE, 1, "R7"); push(I_RBUF, 1, "R7");
    pulse_up();
    drain("R2");
    check(ev_time[I_RUN] - ev_time[I_MUX] >= S, "R2", "settle before run", ev_time[I_RUN] - ev_time[I_MUX], S);
    check(ev_time[I_ON] - ev_time[I_RUN] == P, "R5", "run to first lock sample", ev_time[I_ON] - ev_time[I_RUN], P);

    // R10: up request and slave toggle while on are ignored
    n = ev_cnt;
    slave_en_i = 1'b1;
    pulse_up();
    repeat (40) @(negedge clk_i);
    check(ev_cnt == n, "R10", "changes after up request while on", ev_cnt - n, 0);
    slave_en_i = 1'b0;

    // power-down, master only
    push(I_ON, 0, "R6"); push(I_GATE, 0, "R8"); push(I_RUN, 0, "R8");
    push(I_RBUF, 0, "R8"); push(I_MUX, 0, "R8"); push(I_BIAS, 0, "R8");
    pulse_down();
    while (exp_idx.size() != 0) @(negedge clk_i);
    n = ev_cnt;
    pulse_up();  // during final settle: ignored
    repeat (S + 10) @(negedge clk_i);
    check(ev_cnt == n, "R10", "changes after up request during settle", ev_cnt - n, 0);
    pulse_down(); // idle: ignored
    repeat (20) @(negedge clk_i);
    check(ev_cnt == n, "R10", "changes after down request while idle", ev_cnt - n, 0);

    // power-up with slave, lock arrives mid poll
    lock_i = 1'b0;
    slave_en_i = 1'b1;
    push(I_BIAS, 1, "R2"); push(I_MUX, 1, "R2"); push(I_SBIAS, 1, "R9"); push(I_SMUX, 1, "R9");
    push(I_RUN, 1, "R4"); push(I_ON, 1, "R5"); push(I_GATE, 1, "R7"); push(I_SGATE, 1, "R7");
    push(I_RBUF, 1, "R7"); push(I_SRBUF, 1, "R7");
    pulse_up();
    slave_en_i = 1'b0;
    while (!pll_run_o) @(negedge clk_i);
    repeat (2 * P + P / 2) @(negedge clk_i);
    lock_i = 1'b1;
    drain("R9");
    check(ev_time[I_SBIAS] - ev_time[I_MUX] >= S, "R2", "master settle before slave", ev_time[I_SBIAS] - ev_time[I_MUX], S);
    check(ev_time[I_RUN] - ev_time[I_SMUX] >= S, "R4", "slave settle before run", ev_time[I_RUN] - ev_time[I_SMUX], S);
    check(ev_time[I_ON] - ev_time[I_RUN] == 3 * P, "R5", "lock seen at third sample", ev_time[I_ON] - ev_time[I_RUN], 3 * P);

    // power-down with slave (latched at up, input now low)
    push(I_ON, 0, "R6"); push(I_GATE, 0, "R8"); push(I_RUN, 0, "R8"); push(I_RBUF, 0, "R8");
    push(I_MUX, 0, "R8"); push(I_BIAS, 0, "R8"); push(I_SGATE, 0, "R9"); push(I_SRBUF, 0, "R9");
    push(I_SMUX, 0, "R9"); push(I_SBIAS, 0, "R9");
    pulse_down();
    drain("R8");
    check(ev_time[I_SGATE] - ev_time[I_BIAS] >= S, "R8", "master settle before slave teardown", ev_time[I_SGATE] - ev_time[I_BIAS], S);

    // lock timeout
    lock_i = 1'b0;
    push(I_BIAS, 1, "R2"); push(I_MUX, 1, "R2"); push(I_RUN, 1, "R4"); push(I_ERR, 1, "R5");
    pulse_up();
    drain("R5");
    check(ev_time[I_ERR] - ev_time[I_RUN] == M * P, "R5", "timeout cycles", ev_time[I_ERR] - ev_time[I_RUN], M * P);
    check(!gate_o && !rbuf_o && !pll_on_o, "R7", "gate/buffer/on after timeout", {gate_o, rbuf_o, pll_on_o}, 0);
    n = ev_cnt;
    lock_i = 1'b1;
    pulse_up();
    repeat (3 * P) @(negedge clk_i);
    check(ev_cnt == n, "R10", "changes after up request or lock in fault", ev_cnt - n, 0);
    check(err_o == 1'b1, "R11", "error held in fault", err_o, 1);

    // power-down from fault: gate and buffer already closed
    push(I_RUN, 0, "R8"); push(I_MUX, 0, "R8"); push(I_BIAS, 0, "R8");
    pulse_down();
    drain("R8");
    check(err_o == 1'b1, "R11", "error held after power-down", err_o, 1);

    // next power-up clears the error first
    push(I_ERR, 0, "R11"); push(I_BIAS, 1, "R11"); push(I_MUX, 1, "R2"); push(I_RUN, 1, "R4");
    push(I_ON, 1, "R6"); push(I_GATE, 1, "R7"); push(I_RBUF, 1, "R7");
    pulse_up();
    drain("R11");
    check(ev_time[I_BIAS] - ev_time[I_ERR] == 1, "R11", "error clear to bias", ev_time[I_BIAS] - ev_time[I_ERR], 1);

    push(I_ON, 0, "R6"); push(I_GATE, 0, "R8"); push(I_RUN, 0, "R8");
    push(I_RBUF, 0, "R8"); push(I_MUX, 0, "R8"); push(I_BIAS, 0, "R8");
    pulse_down();
    drain("R8");
    check(obs() == '0, "R8", "all outputs low at end", obs(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule